// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a memory-mapped up-counter with a programmable prescaler and one match channel. A prescale counter runs from zero up to a programmed limit. Each time it wraps, it produces a tick, and every tick advances the main counter by one. When a tick brings the counter to the programmed match value, a match event occurs. A three-bit match configuration decides what the event does: it can set a sticky interrupt flag, restart the counter from zero on the following tick, halt counting, or any mix of the three.

Software reaches the block over a single-cycle register bus. A write takes effect on the clock edge where the write enable is high, and read data is combinational from the address. The run controller is a four-state machine whose state is the two-bit control register:

- `ST_IDLE` (00): counting is halted.
- `ST_RUN` (01): the prescaler and counter advance.
- `ST_HOLD` (10): the counter is held at zero.
- `ST_HOLD_EN` (11): the counter is held at zero and the enable bit is also set.

A write to the control register moves the machine to the state named by the written bits. A match event in `ST_RUN` with halt selected moves it from `ST_RUN` to `ST_IDLE`. If both happen in the same cycle, the software write wins.

Two typical uses follow from this. With reset-on-match, the counter becomes a periodic tick source. With a match value of 1, all three actions selected and the delay written as the prescale value, the block becomes a one-shot delay.

Top module: `pmt_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: While control bit 1 is set, the counter and the prescaler are held at 0, whatever the value of bit 0. Writing 0 to the control register freezes the counter at its current value.
- R3: With control value 01 and prescale value P, the counter rises by one every P+1 clocks. With P = 0 it rises on every clock.
- R4: When no reset-on-match is selected, the counter wraps from its all-ones value to 0.
- R5: A match event occurs on the tick that brings the counter to the match value. `irq` is high in the cycle after that tick's clock edge.
- R6: With match configuration bit 1 set, the counter holds the match value for one tick and then goes to 0, never to match+1.
- R7: With match configuration bit 2 set, a match event sets the control register to 00, and the counter stays frozen at the match value.
- R8: One-shot use works as follows. Set match value 1 and match configuration 111, hold the counter, set prescale to D, then write control 01. `irq` rises D+1 clocks after the enable write's edge.
- R9: The flag at offset 0x00, bit 0, is sticky. Writing 1 to that bit clears it and writing 0 has no effect. A match event in the same cycle as a clearing write leaves the flag set.
- R10: The flag is set only when match configuration bit 0 is 1.
- R11: Writes to the counter register at offset 0x08 are ignored. Reads from unmapped offsets return 0.
- R12: The register offsets are:
  - flag: 0x00
  - control: 0x04
  - counter: 0x08
  - prescale: 0x0C
  - match configuration: 0x14, three bits
  - match value: 0x18

  Counter-width fields read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| irq | output | 1 | Level interrupt, high while the flag is set |

## Verification
Two pairs of actions can land on the same clock edge.

The first pair is a software clear of the interrupt flag and a new match event setting it. The bench runs a short reset-on-match period and clears the flag once between matches, to show that clearing works. It then times a second clearing write so that it lands on the exact edge of the next match, and requires `irq` to stay high.

The second pair is the halt-on-match transition and an ordinary tick. The bench checks that the counter rests on the match value rather than one past it, and that the control register reads 00 afterwards.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int OFS_FLAG  = 'h00;
    localparam int OFS_CTRL  = 'h04;
    localparam int OFS_COUNT = 'h08;
    localparam int OFS_PSC   = 'h0C;
    localparam int OFS_MCFG  = 'h14;
    localparam int OFS_MVAL  = 'h18;

    // match configuration bit positions
    localparam int MCFG_IRQ  = 0;
    localparam int MCFG_CLR  = 1;
    localparam int MCFG_STOP = 2;
    localparam int MCFG_W    = 3;

    // run state encoding equals the control register value {hold, enable}
    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_RUN     = 2'b01,
        ST_HOLD    = 2'b10,
        ST_HOLD_EN = 2'b11
    } run_state_e;

endpackage

// File: rtl/pmt_fsm.sv
module pmt_fsm
    import pmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [1:0] ctrl_wbits,
    input  logic       match_evt,
    input  logic       stop_en,
    output run_state_e state_q,
    output logic       cnt_run,
    output logic       cnt_hold
);

    run_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            state_d = run_state_e'(ctrl_wbits);
        end else if (state_q == ST_RUN && match_evt && stop_en) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cnt_run  = 1'b0;
        cnt_hold = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RUN:     cnt_run  = 1'b1;
            ST_HOLD:    cnt_hold = 1'b1;
            ST_HOLD_EN: cnt_hold = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/pmt_core.sv
module pmt_core #(
    parameter int CNT_W = 32,
    parameter int PS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_run,
    input  logic             cnt_hold,
    input  logic [PS_W-1:0]  psc,
    input  logic [CNT_W-1:0] mval,
    input  logic             clr_en,
    output logic [CNT_W-1:0] count_q,
    output logic             match_evt
);

    logic [PS_W-1:0]  pc_q;
    logic [CNT_W-1:0] count_nxt;
    logic             tick;

    // >= keeps the prescaler from missing its wrap if the limit is lowered
    assign tick      = cnt_run && (pc_q >= psc);
    assign count_nxt = (clr_en && count_q == mval) ? '0 : count_q + 1'b1;
    assign match_evt = tick && (count_nxt == mval);

    always_ff @(posedge clk) begin
        if (!rst_n || cnt_hold) begin
            pc_q    <= '0;
            count_q <= '0;
        end else if (cnt_run) begin
            if (tick) begin
                pc_q    <= '0;
                count_q <= count_nxt;
            end else begin
                pc_q    <= pc_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pmt_regs.sv
module pmt_regs
    import pmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  run_state_e        state,
    input  logic [CNT_W-1:0]  count,
    input  logic              match_evt,
    output logic              ctrl_we,
    output logic [1:0]        ctrl_wbits,
    output logic [PS_W-1:0]   psc_q,
    output logic [CNT_W-1:0]  mval_q,
    output logic [MCFG_W-1:0] mcfg_q,
    output logic              flag_q
);

    logic sel_flag, sel_ctrl, sel_cnt, sel_psc, sel_mcfg, sel_mval;

    assign sel_flag = bus_addr == ADDR_W'(OFS_FLAG);
    assign sel_ctrl = bus_addr == ADDR_W'(OFS_CTRL);
    assign sel_cnt  = bus_addr == ADDR_W'(OFS_COUNT);
    assign sel_psc  = bus_addr == ADDR_W'(OFS_PSC);
    assign sel_mcfg = bus_addr == ADDR_W'(OFS_MCFG);
    assign sel_mval = bus_addr == ADDR_W'(OFS_MVAL);

    assign ctrl_we    = bus_we && sel_ctrl;
    assign ctrl_wbits = bus_wdata[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q  <= '0;
            mval_q <= '0;
            mcfg_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (bus_we && sel_psc)  psc_q  <= bus_wdata[PS_W-1:0];
            if (bus_we && sel_mval) mval_q <= bus_wdata[CNT_W-1:0];
            if (bus_we && sel_mcfg) mcfg_q <= bus_wdata[MCFG_W-1:0];
            // a fresh match outranks a clearing write
            if (match_evt && mcfg_q[MCFG_IRQ]) begin
                flag_q <= 1'b1;
            end else if (bus_we && sel_flag && bus_wdata[0]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_flag) bus_rdata[0]              = flag_q;
        if (sel_ctrl) bus_rdata[1:0]            = state;
        if (sel_cnt)  bus_rdata[CNT_W-1:0]      = count;
        if (sel_psc)  bus_rdata[PS_W-1:0]       = psc_q;
        if (sel_mcfg) bus_rdata[MCFG_W-1:0]     = mcfg_q;
        if (sel_mval) bus_rdata[CNT_W-1:0]      = mval_q;
    end

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    run_state_e        run_state;
    logic              cnt_run, cnt_hold;
    logic              ctrl_we;
    logic [1:0]        ctrl_wbits;
    logic [PS_W-1:0]   psc_q;
    logic [CNT_W-1:0]  mval_q;
    logic [MCFG_W-1:0] mcfg_q;
    logic              flag_q;
    logic [CNT_W-1:0]  count_q;
    logic              match_evt;

    pmt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PS_W(PS_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .state(run_state), .count(count_q), .match_evt(match_evt),
        .ctrl_we(ctrl_we), .ctrl_wbits(ctrl_wbits),
        .psc_q(psc_q), .mval_q(mval_q), .mcfg_q(mcfg_q), .flag_q(flag_q)
    );

    pmt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wbits(ctrl_wbits),
        .match_evt(match_evt), .stop_en(mcfg_q[MCFG_STOP]),
        .state_q(run_state), .cnt_run(cnt_run), .cnt_hold(cnt_hold)
    );

    pmt_core #(.CNT_W(CNT_W), .PS_W(PS_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .cnt_run(cnt_run), .cnt_hold(cnt_hold),
        .psc(psc_q), .mval(mval_q), .clr_en(mcfg_q[MCFG_CLR]),
        .count_q(count_q), .match_evt(match_evt)
    );

    assign irq = flag_q;

endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk
    import pmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [1:0]        state,
    input logic [CNT_W-1:0]  count,
    input logic [MCFG_W-1:0] mcfg
);

    a_r2_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        state[1] |=> (count == '0));

    a_r7_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b00) |=> $stable(count));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b01) |=> (count == $past(count) ||
                              count == $past(count) + CNT_W'(1) ||
                              count == '0));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_we && bus_addr == ADDR_W'(OFS_FLAG) && bus_wdata[0]))
        |=> irq);

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !mcfg[MCFG_IRQ]) |=> !irq);

endmodule

bind pmt_timer pmt_timer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq), .state(run_state),
    .count(count_q), .mcfg(mcfg_q)
);

// File: tb/pmt_timer_tb.sv
module pmt_timer_tb;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int PS_W   = 32;

    localparam logic [7:0] A_FLAG = 8'h00, A_CTRL = 8'h04, A_CNT = 8'h08,
                           A_PSC = 8'h0C, A_MCFG = 8'h14, A_MVAL = 8'h18;

    // {write, addr, data, expected}
    localparam int NV = 13;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, A_PSC,  32'h0000_0005, 32'h0},
        {1'b0, A_PSC,  32'h0,         32'h0000_0005},   // R12
        {1'b1, A_MVAL, 32'h0001_1234, 32'h0},
        {1'b0, A_MVAL, 32'h0,         32'h0000_1234},   // R12 zero-extended
        {1'b1, A_MCFG, 32'hFFFF_FFFF, 32'h0},
        {1'b0, A_MCFG, 32'h0,         32'h0000_0007},   // R12
        {1'b1, A_CNT,  32'h0000_AAAA, 32'h0},
        {1'b0, A_CNT,  32'h0,         32'h0},           // R11 write ignored
        {1'b0, 8'h10,  32'h0,         32'h0},           // R11 unmapped
        {1'b0, 8'h1C,  32'h0,         32'h0},           // R11 unmapped
        {1'b1, A_MCFG, 32'h0,         32'h0},
        {1'b1, A_PSC,  32'h0,         32'h0},
        {1'b0, A_MCFG, 32'h0,         32'h0}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_we;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    pmt_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PS_W(PS_W))
    u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        wait_n(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_CNT, v);  check("R1 count", v, 0);
        rd(A_FLAG, v); check("R1 flag", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // register map vectors (R11, R12)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                wr(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                rd(VEC[i][71:64], v);
                check($sformatf("R11/R12 vec %0d", i), v, VEC[i][31:0]);
            end
        end

        // R3 prescale 0: one step per clock
        wr(A_CTRL, 2); wr(A_CTRL, 1);
        wait_n(10);
        rd(A_CNT, v); check("R3 p0 count", v, 10);
        // R2 freeze on write 0 (one more step on the write edge)
        wr(A_CTRL, 0);
        wait_n(5);
        rd(A_CNT, v); check("R2 freeze", v, 11);
        // R2 hold with enable also set
        wr(A_CTRL, 3);
        wait_n(3);
        rd(A_CNT, v); check("R2 hold en", v, 0);

        // R3 prescale 3: one step per 4 clocks
        wr(A_PSC, 3); wr(A_CTRL, 1);
        wait_n(19);
        rd(A_CNT, v); check("R3 p3 before", v, 4);
        wait_n(1);
        rd(A_CNT, v); check("R3 p3 step", v, 5);

        // R4 wrap, R10 no flag with irq bit clear (match value 0x1234 passed)
        wr(A_CTRL, 2); wr(A_PSC, 0); wr(A_CTRL, 1);
        wait_n(65535);
        rd(A_CNT, v); check("R4 all ones", v, 32'hFFFF);
        wait_n(1);
        rd(A_CNT, v); check("R4 wrap", v, 0);
        check("R10 no irq", {31'b0, irq}, 0);

        // R5/R6 match with irq and reset, match value 4
        wr(A_CTRL, 2); wr(A_MVAL, 4); wr(A_MCFG, 3); wr(A_CTRL, 1);
        wait_n(3);
        check("R5 irq before", {31'b0, irq}, 0);
        wait_n(1);
        check("R5 irq at match", {31'b0, irq}, 1);
        rd(A_CNT, v); check("R6 holds match", v, 4);
        wait_n(1);
        rd(A_CNT, v); check("R6 restart", v, 0);
        wr(A_CTRL, 0);
        // R9 write 0 ignored, write 1 clears
        wr(A_FLAG, 0);
        check("R9 write0", {31'b0, irq}, 1);
        wr(A_FLAG, 1);
        rd(A_FLAG, v); check("R9 clear", v, 0);

        // R9 priority: match value 2, period 3
        wr(A_CTRL, 2); wr(A_MVAL, 2); wr(A_CTRL, 1);
        wait_n(2);
        check("R9 set", {31'b0, irq}, 1);
        wr(A_FLAG, 1);
        check("R9 cleared between", {31'b0, irq}, 0);
        wait_n(1);
        wr(A_FLAG, 1);              // lands on the next match edge
        check("R9 match wins", {31'b0, irq}, 1);
        wr(A_CTRL, 0); wr(A_FLAG, 1);

        // R8 one-shot with delay 5, R7 self-stop
        wr(A_MVAL, 1); wr(A_MCFG, 7); wr(A_CTRL, 2); wr(A_PSC, 5);
        wr(A_CTRL, 1);
        wait_n(5);
        check("R8 before delay", {31'b0, irq}, 0);
        wait_n(1);
        check("R8 fires", {31'b0, irq}, 1);
        rd(A_CTRL, v); check("R7 ctrl stopped", v, 0);
        wait_n(20);
        rd(A_CNT, v); check("R7 frozen at match", v, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule